// File: doc/BRIEF.md
# Port Pin Function Multiplexer

This block sits between the pads of an 8-bit port and the logic behind it. Each pin has a 2-bit function code. Code zero hands the pin to plain GPIO, and the three other codes hand it to one of three peripheral lanes. The code decides which source drives the pad's output value. It also decides whether the pad's output enable comes from the direction register or from the peripheral. A peripheral drives the output enable only when a per-pin, per-function parameter marks it as the owner of direction.

Incoming pad values go to the peripherals through a forwarded input. This input follows the pad while the pin is in a peripheral function. When the pin is handed back to GPIO, the forwarded input freezes at the last value it saw, so a peripheral never sees the plain GPIO traffic that follows. A drive-strength register requests high drive, and the request reaches the pad only on pins that a parameter marks as able to drive hard. The registers are loaded through simple write strobes that share one data bus. A separate flip strobe inverts the chosen bits of both select registers on the same edge.

Top module: `gpio_func_mux`

## Requirements
- R1: The function code of pin p is {sel1[p], sel0[p]}. With code 00, pad_out[p] takes the output register bit. With codes 01, 10 and 11, pad_out[p] takes per_out[(code-1)*NPINS + p].
- R2: With code 00, pad_oe[p] equals the direction bit. The same holds for any function whose direction-owner mask bit is clear. Writing a select register, or flipping it, leaves the direction register unchanged.
- R3: For code c != 00 with DIR_OWN_MASK[(c-1)*NPINS + p] set, pad_oe[p] equals per_oe[(c-1)*NPINS + p], and the direction bit has no effect on it.
- R4: While the code of pin p is non-zero, per_in[p] equals pad_in[p] in the same cycle.
- R5: While the code of pin p is 00, per_in[p] holds the pad_in[p] value sampled at the last clock edge at which the code was still non-zero. After reset that value is 0.
- R6: pad_hidrive[p] equals the drive-strength bit when HIDRV_MASK[p] is set. It is 0 on every other pin, whatever the drive-strength bit holds.
- R7: A synchronous active-low reset clears the select, direction, output, drive-strength and hold registers. All pins then start in GPIO mode with pad_oe = 0, pad_out = 0 and per_in = 0.
- R8: A flip strobe XORs wr_data into both select registers on the same edge. A write strobe to one of those registers in that same cycle takes precedence for that register.
- R9: Each write strobe loads wr_data into its register on the clock edge. The new value shows at the outputs from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_sel0 | input | 1 | Load select-0 register from wr_data |
| wr_sel1 | input | 1 | Load select-1 register from wr_data |
| wr_sel_flip | input | 1 | XOR wr_data into both select registers |
| wr_dir | input | 1 | Load direction register |
| wr_out | input | 1 | Load output register |
| wr_drv | input | 1 | Load drive-strength register |
| wr_data | input | NPINS | Shared write data |
| pad_in | input | NPINS | Values present at the pads |
| per_out | input | 3*NPINS | Peripheral output values, lane-major |
| per_oe | input | 3*NPINS | Peripheral output enables, lane-major |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Output enable of each pad |
| pad_hidrive | output | NPINS | High-drive request per pad |
| per_in | output | NPINS | Pad input as forwarded to the peripherals |

## Verification
The bench checks the hold-on-return path in three ways: it hands pins back to GPIO while pad_in is moving, changes pad_in afterwards, and then re-enters a function. A design that sampled one cycle late, or let the held value leak through, would show the new pad value on per_in. It also flips the select registers from 01 to 10 on pins whose lanes differ. A design that applied the flip in two steps would expose an intermediate lane's output or output enable for a cycle. Direction-owning lanes are driven with per_oe opposite to the direction register, so a mux that ignored the mask would drive the wrong enable. The drive-strength register is set to all ones, so a design that forwarded it to pins without high-drive capability would raise pad_hidrive there.

// File: rtl/gpio_mux_pkg.sv
// Shared types for the pin function multiplexer.
// Assumes a 2-bit code per pin: one GPIO code plus three peripheral codes.
package gpio_mux_pkg;

    localparam int FN_COUNT = 3;

    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_ALT1 = 2'b01,
        FN_ALT2 = 2'b10,
        FN_ALT3 = 2'b11
    } pin_fn_e;

    // Next value of a select register under load and flip strobes (load wins)
    function automatic logic [7:0] sel_next8(input logic [7:0] cur,
                                             input logic load,
                                             input logic flip,
                                             input logic [7:0] data);
        logic [7:0] r;
        if (load)      r = data;
        else if (flip) r = cur ^ data;
        else           r = cur;
        return r;
    endfunction

endpackage

// File: rtl/gpio_mux_regs.sv
// Configuration registers of the port: two select planes, direction,
// output value and drive strength. Every register is loaded from the
// shared data bus by its own strobe. The flip strobe XORs the data into
// both select planes on one edge, and a load of the same plane wins.
// Assumes the strobes are single-cycle pulses that are valid at the clock edge.
module gpio_mux_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel0,
    input  logic             wr_sel1,
    input  logic             wr_sel_flip,
    input  logic             wr_dir,
    input  logic             wr_out,
    input  logic             wr_drv,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] sel0_q,
    output logic [NPINS-1:0] sel1_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] drv_q
);

    localparam int PLANES = 2;

    logic [NPINS-1:0] plane_q    [PLANES];
    logic             plane_load [PLANES];

    assign plane_load[0] = wr_sel0;
    assign plane_load[1] = wr_sel1;

    // One register per select plane, both sharing the flip strobe
    for (genvar g = 0; g < PLANES; g++) begin : g_plane
        always_ff @(posedge clk) begin
            if (!rst_n)
                plane_q[g] <= '0;
            else if (plane_load[g])
                plane_q[g] <= wr_data;
            else if (wr_sel_flip)
                plane_q[g] <= plane_q[g] ^ wr_data;
        end
    end

    assign sel0_q = plane_q[0];
    assign sel1_q = plane_q[1];

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wr_data;
    end

    // Output value register
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_out) out_q <= wr_data;
    end

    // Drive-strength register
    always_ff @(posedge clk) begin
        if (!rst_n)      drv_q <= '0;
        else if (wr_drv) drv_q <= wr_data;
    end

endmodule

// File: rtl/gpio_mux_inhold.sv
// Forwarded input of one pin. While the pin is in a peripheral function,
// the pad value passes straight through. When the pin drops back to GPIO,
// the output keeps the value captured at the last edge at which the
// function was still active.
// Assumes pad_in is already synchronised to clk.
module gpio_mux_inhold (
    input  logic clk,
    input  logic rst_n,
    input  logic fn_active,
    input  logic pad_in,
    output logic per_in
);

    logic hold_q;

    // Track the pad while a function is active, freeze otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= 1'b0;
        else if (fn_active) hold_q <= pad_in;
    end

    // Live pad while active, frozen sample in GPIO
    always_comb begin
        per_in = fn_active ? pad_in : hold_q;
    end

endmodule

// File: rtl/gpio_mux_lane.sv
// Output path of one pin. The function code picks the value and the
// enable driven to the pad. A lane marked in OWN_DIR supplies its own
// enable. Otherwise the direction bit is used. High drive is passed on
// only when HIDRV_CAP is set.
// Assumes a per_out/per_oe index of 0 for code 01, 1 for code 10 and 2 for code 11.
module gpio_mux_lane
    import gpio_mux_pkg::*;
#(
    parameter logic [FN_COUNT-1:0] OWN_DIR   = '0,
    parameter bit                  HIDRV_CAP = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pin_fn_e             fn,
    input  logic                dir,
    input  logic                out,
    input  logic                drv,
    input  logic                pad_in,
    input  logic [FN_COUNT-1:0] lane_out,
    input  logic [FN_COUNT-1:0] lane_oe,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_hidrive,
    output logic                per_in
);

    logic fn_active;

    assign fn_active = (fn != FN_GPIO);

    // Pick the pad value and enable from the selected source
    always_comb begin
        unique case (fn)
            FN_ALT1: begin
                pad_out = lane_out[0];
                pad_oe  = OWN_DIR[0] ? lane_oe[0] : dir;
            end
            FN_ALT2: begin
                pad_out = lane_out[1];
                pad_oe  = OWN_DIR[1] ? lane_oe[1] : dir;
            end
            FN_ALT3: begin
                pad_out = lane_out[2];
                pad_oe  = OWN_DIR[2] ? lane_oe[2] : dir;
            end
            default: begin
                pad_out = out;
                pad_oe  = dir;
            end
        endcase
    end

    // Drive-strength request reaches only high-drive capable pads
    if (HIDRV_CAP) begin : g_hidrv
        assign pad_hidrive = drv;
    end else begin : g_regdrv
        logic drv_unused;
        assign drv_unused  = drv;
        assign pad_hidrive = 1'b0;
    end

    gpio_mux_inhold u_inhold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn_active (fn_active),
        .pad_in    (pad_in),
        .per_in    (per_in)
    );

endmodule

// File: rtl/gpio_func_mux.sv
// Function multiplexer of one port. The configuration registers feed one
// lane per pin. Peripheral buses are lane-major: bit f*NPINS+p belongs to
// function code f+1 on pin p. DIR_OWN_MASK uses the same layout, and
// HIDRV_MASK has one bit per pin.
// Assumes all inputs are synchronous to clk.
module gpio_func_mux
    import gpio_mux_pkg::*;
#(
    parameter int                         NPINS        = 8,
    parameter logic [FN_COUNT*NPINS-1:0]  DIR_OWN_MASK = 24'hF0_0F_00,
    parameter logic [NPINS-1:0]           HIDRV_MASK   = 8'h30
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_sel0,
    input  logic                      wr_sel1,
    input  logic                      wr_sel_flip,
    input  logic                      wr_dir,
    input  logic                      wr_out,
    input  logic                      wr_drv,
    input  logic [NPINS-1:0]          wr_data,
    input  logic [NPINS-1:0]          pad_in,
    input  logic [FN_COUNT*NPINS-1:0] per_out,
    input  logic [FN_COUNT*NPINS-1:0] per_oe,
    output logic [NPINS-1:0]          pad_out,
    output logic [NPINS-1:0]          pad_oe,
    output logic [NPINS-1:0]          pad_hidrive,
    output logic [NPINS-1:0]          per_in
);

    logic [NPINS-1:0] sel0_q;
    logic [NPINS-1:0] sel1_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] drv_q;

    // Gather the direction-owner bits of one pin across all functions
    function automatic logic [FN_COUNT-1:0] own_of(input int pin);
        logic [FN_COUNT-1:0] r;
        for (int f = 0; f < FN_COUNT; f++)
            r[f] = DIR_OWN_MASK[f*NPINS + pin];
        return r;
    endfunction

    gpio_mux_regs #(.NPINS(NPINS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel0     (wr_sel0),
        .wr_sel1     (wr_sel1),
        .wr_sel_flip (wr_sel_flip),
        .wr_dir      (wr_dir),
        .wr_out      (wr_out),
        .wr_drv      (wr_drv),
        .wr_data     (wr_data),
        .sel0_q      (sel0_q),
        .sel1_q      (sel1_q),
        .dir_q       (dir_q),
        .out_q       (out_q),
        .drv_q       (drv_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [FN_COUNT-1:0] lane_out;
        logic [FN_COUNT-1:0] lane_oe;
        pin_fn_e             fn;

        // Regroup the lane-major peripheral buses per pin
        for (genvar f = 0; f < FN_COUNT; f++) begin : g_fn
            assign lane_out[f] = per_out[f*NPINS + p];
            assign lane_oe[f]  = per_oe[f*NPINS + p];
        end

        assign fn = pin_fn_e'({sel1_q[p], sel0_q[p]});

        gpio_mux_lane #(
            .OWN_DIR   (own_of(p)),
            .HIDRV_CAP (HIDRV_MASK[p])
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .fn          (fn),
            .dir         (dir_q[p]),
            .out         (out_q[p]),
            .drv         (drv_q[p]),
            .pad_in      (pad_in[p]),
            .lane_out    (lane_out),
            .lane_oe     (lane_oe),
            .pad_out     (pad_out[p]),
            .pad_oe      (pad_oe[p]),
            .pad_hidrive (pad_hidrive[p]),
            .per_in      (per_in[p])
        );
    end

endmodule

// File: rtl/gpio_mux_chk.sv
// Checker for the port function multiplexer, bound to every instance.
// Reads the select and direction registers inside the top.
module gpio_mux_chk #(
    parameter int                  NPINS        = 8,
    parameter logic [3*NPINS-1:0]  DIR_OWN_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_sel0,
    input logic               wr_sel1,
    input logic               wr_sel_flip,
    input logic               wr_dir,
    input logic [NPINS-1:0]   wr_data,
    input logic [NPINS-1:0]   sel0_q,
    input logic [NPINS-1:0]   sel1_q,
    input logic [NPINS-1:0]   dir_q,
    input logic [NPINS-1:0]   pad_in,
    input logic [3*NPINS-1:0] per_oe,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   per_in
);

    logic [NPINS-1:0] active;
    logic [NPINS-1:0] own_now;
    logic [NPINS-1:0] lane_oe_now;

    assign active = sel0_q | sel1_q;

    // Per pin: does the active lane own direction, and what enable it offers
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            own_now[p]     = 1'b0;
            lane_oe_now[p] = 1'b0;
            if (active[p]) begin
                own_now[p]     = DIR_OWN_MASK[(int'({sel1_q[p], sel0_q[p]}) - 1)*NPINS + p];
                lane_oe_now[p] = per_oe[(int'({sel1_q[p], sel0_q[p]}) - 1)*NPINS + p];
            end
        end
    end

    AST_RESET_GPIO: assert property (@(posedge clk)
        rst_n && $past(!rst_n) |-> (sel0_q == '0) && (sel1_q == '0) && (dir_q == '0) && (per_in == '0)); // R7

    AST_FLIP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel_flip && !wr_sel0 && !wr_sel1 |=>
            (sel0_q == ($past(sel0_q) ^ $past(wr_data))) && (sel1_q == ($past(sel1_q) ^ $past(wr_data)))); // R8

    AST_DIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel0 || wr_sel1 || wr_sel_flip) && !wr_dir |=> $stable(dir_q)); // R2

    AST_GPIO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~active | ~own_now) & (pad_oe ^ dir_q)) == '0); // R2

    AST_OWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (own_now & (pad_oe ^ lane_oe_now)) == '0); // R3

    AST_FOLLOW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (active & (per_in ^ pad_in)) == '0); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_in ^ $past(per_in)) & ~active & ~$past(active)) == '0); // R5

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_in ^ $past(pad_in)) & ~active & $past(active)) == '0); // R5

endmodule

bind gpio_func_mux gpio_mux_chk #(
    .NPINS        (NPINS),
    .DIR_OWN_MASK (DIR_OWN_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_sel0     (wr_sel0),
    .wr_sel1     (wr_sel1),
    .wr_sel_flip (wr_sel_flip),
    .wr_dir      (wr_dir),
    .wr_data     (wr_data),
    .sel0_q      (sel0_q),
    .sel1_q      (sel1_q),
    .dir_q       (dir_q),
    .pad_in      (pad_in),
    .per_oe      (per_oe),
    .pad_oe      (pad_oe),
    .per_in      (per_in)
);

// File: tb/gpio_func_mux_bench.sv
// Bench: behavioural reference model, compared against the outputs every cycle.
module gpio_func_mux_bench;

    localparam int          N     = 8;
    localparam logic [23:0] OWN   = 24'hF0_0F_00;
    localparam logic [7:0]  HCAP  = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_sel0 = 0, wr_sel1 = 0, wr_sel_flip = 0;
    logic        wr_dir = 0, wr_out = 0, wr_drv = 0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  pad_in = 8'hA5;
    logic [23:0] per_out = '0;
    logic [23:0] per_oe = '0;
    logic [7:0]  pad_out, pad_oe, pad_hidrive, per_in;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    cmp_en   = 0;
    string phase    = "reset";

    // Model state
    logic [7:0] m_s0 = '0, m_s1 = '0, m_dir = '0, m_out = '0, m_drv = '0, m_hold = '0;

    always #2 clk = ~clk;

    gpio_func_mux #(.NPINS(N), .DIR_OWN_MASK(OWN), .HIDRV_MASK(HCAP)) u_gpio_func_mux (
        .clk(clk), .rst_n(rst_n), .wr_sel0(wr_sel0), .wr_sel1(wr_sel1),
        .wr_sel_flip(wr_sel_flip), .wr_dir(wr_dir), .wr_out(wr_out), .wr_drv(wr_drv),
        .wr_data(wr_data), .pad_in(pad_in), .per_out(per_out), .per_oe(per_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_hidrive(pad_hidrive), .per_in(per_in)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s (%s) %s: actual %h expected %h", req, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] e_out, e_oe, e_hid, e_in;
        for (int p = 0; p < N; p++) begin
            int code;
            code = {m_s1[p], m_s0[p]};
            if (code == 0) begin
                e_out[p] = m_out[p];
                e_oe[p]  = m_dir[p];
                e_in[p]  = m_hold[p];
            end else begin
                int lane;
                lane = (code - 1) * N + p;
                e_out[p] = per_out[lane];
                e_oe[p]  = OWN[lane] ? per_oe[lane] : m_dir[p];
                e_in[p]  = pad_in[p];
            end
            e_hid[p] = HCAP[p] ? m_drv[p] : 1'b0;
        end
        check("R1", "pad_out", pad_out, e_out);
        check("R2/R3", "pad_oe", pad_oe, e_oe);
        check("R4/R5", "per_in", per_in, e_in);
        check("R6", "pad_hidrive", pad_hidrive, e_hid);
    endtask

    task automatic model_update();
        if (!rst_n) begin
            m_s0 = '0; m_s1 = '0; m_dir = '0; m_out = '0; m_drv = '0; m_hold = '0;
        end else begin
            for (int p = 0; p < N; p++)
                if (m_s0[p] || m_s1[p]) m_hold[p] = pad_in[p];
            m_s0 = wr_sel0 ? wr_data : (wr_sel_flip ? (m_s0 ^ wr_data) : m_s0);
            m_s1 = wr_sel1 ? wr_data : (wr_sel_flip ? (m_s1 ^ wr_data) : m_s1);
            if (wr_dir) m_dir = wr_data;
            if (wr_out) m_out = wr_data;
            if (wr_drv) m_drv = wr_data;
        end
    endtask

    // Compare before the edge, advance the model at the edge, return at negedge
    task automatic tick();
        #1;
        if (cmp_en) compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        {wr_sel0, wr_sel1, wr_sel_flip, wr_dir, wr_out, wr_drv} = '0;
    endtask

    task automatic wr(input int which, input logic [7:0] d);
        wr_data = d;
        case (which)
            0: wr_sel0 = 1;
            1: wr_sel1 = 1;
            2: wr_sel_flip = 1;
            3: wr_dir = 1;
            4: wr_out = 1;
            default: wr_drv = 1;
        endcase
        tick();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R7: reset state, GPIO with pads off and the forwarded input cleared
        phase = "R7";
        check("R7", "pad_oe after reset", pad_oe, 8'h00);
        check("R7", "pad_out after reset", pad_out, 8'h00);
        check("R7", "per_in after reset", per_in, 8'h00);
        check("R7", "pad_hidrive after reset", pad_hidrive, 8'h00);
        cmp_en = 1;
        tick();

        // R9: register loads visible the cycle after the strobe
        phase = "R9";
        wr(4, 8'h5A);
        wr(3, 8'hFF);
        wr(5, 8'hFF);      // R6: only pins 4 and 5 may raise high drive
        tick();
        phase = "R6";
        wr(5, 8'hCF);
        tick();

        // R1: each function code in turn, lanes carry distinct patterns
        phase = "R1";
        per_out = 24'h3C_C3_96;
        per_oe  = 24'h0F_F0_55;
        wr(0, 8'hFF);      // code 01
        pad_in = 8'h11; tick();
        wr(0, 8'h00); wr(1, 8'hFF);   // code 10
        wr(0, 8'hFF);      // code 11
        wr(0, 8'hAA); wr(1, 8'hCC);   // mixed codes
        tick();

        // R3: owned lanes drive enable against the direction register
        phase = "R3";
        wr(3, 8'h00);
        per_oe = 24'hFF_FF_00; tick();
        per_oe = 24'h00_00_FF; tick();
        wr(3, 8'hFF); tick();

        // R4: live following while in a function
        phase = "R4";
        wr(0, 8'hFF); wr(1, 8'h00);
        pad_in = 8'h0F; tick();
        pad_in = 8'hF0; tick();

        // R5: return to GPIO while the pad moves, then the pad changes again
        phase = "R5";
        pad_in = 8'h69;
        wr(0, 8'h00);
        pad_in = 8'h96; tick();
        pad_in = 8'h00; tick();
        wr(0, 8'h0F);      // re-enter on pins 0..3 only
        pad_in = 8'hFF; tick();
        wr(0, 8'h00);
        pad_in = 8'h12; tick();

        // R8: flip 01 -> 10 in one edge, then flip with a same-cycle load
        phase = "R8";
        wr(0, 8'hFF); wr(1, 8'h00);
        wr(2, 8'hFF);
        tick();
        wr_sel0 = 1; wr_data = 8'h33; wr_sel_flip = 1; tick();
        tick();
        wr(2, 8'h0F);
        tick();

        // Mixed traffic
        phase = "random";
        for (int i = 0; i < 600; i++) begin
            int r;
            pad_in  = 8'($urandom);
            per_out = 24'($urandom);
            per_oe  = 24'($urandom);
            wr_data = 8'($urandom);
            r = $urandom_range(0, 15);
            wr_sel0     = (r == 0) || (r == 6);
            wr_sel1     = (r == 1) || (r == 7);
            wr_sel_flip = (r == 2) || (r == 6) || (r == 8);
            wr_dir      = (r == 3) || (r == 8);
            wr_out      = (r == 4);
            wr_drv      = (r == 5);
            tick();
        end

        finish_run();
    end

endmodule